// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Indexed and Policy Insert

This block holds a small set of address translations and searches all of them in parallel. A lookup presents a virtual address, a context number and a real-mode flag. An entry matches when its stored partition equals the current partition register, its real-mode flag equals the request, its context equals the request (real-mode entries ignore context), and the virtual page bits above the entry's page size agree. One cycle later the block reports hit or miss, the matching entry number and the physical address. The physical address takes the page bits from the entry and the offset bits from the request. A miss loads the tag-access register with the missing page and context, ready for a refill.

Entries are written through one configuration write port. The port has four targets: the tag-access register, the partition register, a fill that picks the slot with a not-recently-used policy, and a fill into an explicit slot whose number is carried in the write address. A fill takes its virtual tag and context from the tag-access register and its partition from the partition register. The written page descriptor is stored in the native layout, or it is first rearranged from the alternate layout when an address bit asks for it.

Top module: `tlb_fa`

## Requirements
- R1: While `rst` is high and after its release, every entry is invalid, all used bits are clear, the tag-access and partition registers are zero and `rsp_valid` is low, so the first lookup misses.
- R2: `rsp_valid` is high in the cycle after each cycle with `lk_req` high and low otherwise. `rsp_hit` is set only when a valid entry matches the stored partition, the real-mode flag, the context (not compared for real-mode entries) and `lk_va` above the page size. When several entries match, the lowest number is reported in `rsp_idx`.
- R3: The native descriptor holds valid at bit 63, the size code as {bit 48, bits 62:61} and the physical page at bits 39:13. Codes 0 to 5 give page shifts 13, 16, 19, 22, 25 and 28. `rsp_pa` is the page address with the low shift bits cleared, ORed with those low bits of `lk_va`.
- R4: An entry whose size code is 6 or 7 never hits.
- R5: A lookup that misses loads the tag-access register with {`lk_va`[63:13], `lk_ctx`}. A tag-access write in the same cycle takes precedence. `tag_access_o` always shows the register.
- R6: `cfg_sel` selects the write target: 0 writes the tag-access register with all 64 bits, 1 writes the partition register from the low `PART_W` bits, 2 performs a policy fill and 3 performs an indexed fill.
- R7: A fill stores tag-access bits 63:13 as the virtual tag, bits 12:0 as the context, the partition register as the partition, and `cfg_addr` bit 9 as the real-mode flag. It also clears that entry's used bit.
- R8: A policy fill writes the lowest-numbered entry that is invalid or has its used bit clear. If there is none, it writes the last entry.
- R9: An indexed fill writes the entry numbered by `cfg_addr` bits [3 +: log2(ENTRIES)] (bits 8:3 for 64 entries) and ignores the policy.
- R10: With `cfg_addr` bit 10 set, the written data is converted from the alternate layout: 63 to valid 63, 1:0 to 62:61, 2 to 48, 62 to 60, 12 to 59, 39:13 to 39:13, 61 to lock 6, 10 to 5, 9 to 4, 11 to 3, 8 to 2, 6 to 1. Every other bit is zero.
- R11: A hit sets the entry's used bit. If that would leave every entry used, the used bits are reduced to the locked valid entries (lock bit 6) plus the entry just hit. `used_cnt` equals the number of used bits set.
- R12: A lookup in the same cycle as a configuration write sees the contents from before that write, and a policy fill in that cycle chooses its slot from the used bits before that hit. If the fill and the hit name the same entry, the fill wins and its used bit ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target (R6) |
| cfg_addr | input | 11 | Write address: bit 10 alternate layout, bit 9 real mode, slot number from bit 3 |
| cfg_wdata | input | 64 | Write data |
| tag_access_o | output | 64 | Current tag-access register |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_rmode | input | 1 | Lookup real-mode flag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | log2(ENTRIES) | Hitting entry number |
| rsp_pa | output | 40 | Translated physical address |
| used_cnt | output | log2(ENTRIES)+1 | Number of entries with the used bit set |

## Verification
A lookup and a configuration write can occur in the same cycle. A lookup miss can coincide with a tag-access write, and a hit on an entry can coincide with a fill that overwrites that entry or that consults the used bits. The bench provokes both cases on purpose and also mixes thousands of random cycles in which the two happen together. An array model advances on the rules of R5, R11 and R12. The bench judges the outcome from the response fields, `used_cnt` and `tag_access_o` after each cycle, and by looking up the refilled entries afterwards.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W   = 64;
  localparam int PA_W   = 40;
  localparam int CTX_W  = 13;
  localparam int PG_LSB = 13;
  localparam int VTAG_W = VA_W - PG_LSB;

  // native descriptor bit positions
  localparam int B_VALID = 63;
  localparam int B_SZ_HI = 62;
  localparam int B_SZ_LO = 61;
  localparam int B_NFO   = 60;
  localparam int B_IE    = 59;
  localparam int B_SZ2   = 48;
  localparam int B_PA_HI = 39;
  localparam int B_LOCK  = 6;
  localparam int B_CP    = 5;
  localparam int B_CV    = 4;
  localparam int B_SE    = 3;
  localparam int B_PRIV  = 2;
  localparam int B_WR    = 1;

  localparam int SHIFT_STEP = 3;
  localparam logic [2:0] SZ_LIMIT = 3'd6;

  typedef enum logic [1:0] {
    CFG_TAG  = 2'd0,
    CFG_PART = 2'd1,
    CFG_FILL = 2'd2,
    CFG_SLOT = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [VTAG_W-1:0] vtag;
    logic [CTX_W-1:0]  ctx;
    logic              rmode;
    logic [63:0]       pte;
  } tlb_entry_t;

  function automatic logic [2:0] size_code(input logic [63:0] pte);
    return {pte[B_SZ2], pte[B_SZ_HI:B_SZ_LO]};
  endfunction

  function automatic logic [5:0] page_shift(input logic [2:0] code);
    return 6'(PG_LSB + SHIFT_STEP * int'(code));
  endfunction

endpackage

// File: rtl/tlb_pte_fmt.sv
module tlb_pte_fmt
  import tlb_pkg::*;
(
  input  logic        alt,
  input  logic [63:0] raw,
  output logic [63:0] native
);

  always_comb begin
    if (!alt) begin
      native = raw;
    end else begin
      native                  = '0;
      native[B_VALID]         = raw[63];
      native[B_SZ_HI:B_SZ_LO] = raw[1:0];
      native[B_SZ2]           = raw[2];
      native[B_NFO]           = raw[62];
      native[B_IE]            = raw[12];
      native[B_PA_HI:PG_LSB]  = raw[39:13];
      native[B_LOCK]          = raw[61];
      native[B_CP]            = raw[10];
      native[B_CV]            = raw[9];
      native[B_SE]            = raw[11];
      native[B_PRIV]          = raw[8];
      native[B_WR]            = raw[6];
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PART_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  tlb_entry_t [ENTRIES-1:0]         ents,
  input  logic [ENTRIES-1:0][PART_W-1:0]   parts,
  input  logic [PART_W-1:0]                part_cur,
  input  logic [VA_W-1:0]                  lk_va,
  input  logic [CTX_W-1:0]                 lk_ctx,
  input  logic                             lk_rmode,
  output logic [ENTRIES-1:0]               hit_vec
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [2:0]      code;
    logic [5:0]      sh;
    logic [VA_W-1:0] pg_mask;
    logic [VA_W-1:0] tag_va;
    logic            size_ok;
    logic            ctx_ok;

    always_comb begin
      code    = size_code(ents[g].pte);
      sh      = page_shift(code);
      pg_mask = ~((64'd1 << sh) - 64'd1);
      tag_va  = {ents[g].vtag, {PG_LSB{1'b0}}};
      size_ok = (code < SZ_LIMIT);
      ctx_ok  = ents[g].rmode || (ents[g].ctx == lk_ctx);
    end

    assign hit_vec[g] = ents[g].pte[B_VALID] && size_ok && ctx_ok
                        && (parts[g] == part_cur)
                        && (ents[g].rmode == lk_rmode)
                        && ((lk_va & pg_mask) == (tag_va & pg_mask));

    AST_BADSIZE_NOHIT: assert property (@(posedge clk) disable iff (rst)
      (size_code(ents[g].pte) >= SZ_LIMIT) |-> !hit_vec[g]); // R4
  end

endmodule

// File: rtl/tlb_nru.sv
module tlb_nru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] locked_vec,
  input  logic               hit_en,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  output logic [ENTRIES-1:0] used_q,
  output logic [IDX_W-1:0]   victim,
  output logic [IDX_W:0]     used_cnt
);

  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] used_nxt;
  logic [ENTRIES-1:0] hit_onehot;

  assign free_vec   = ~valid_vec | ~used_q;
  assign hit_onehot = ENTRIES'(1) << hit_idx;

  // lowest free slot, else the last one
  always_comb begin
    victim = IDX_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) victim = IDX_W'(i);
    end
  end

  always_comb begin
    used_nxt = used_q;
    if (hit_en) begin
      used_nxt = used_q | hit_onehot;
      if (&used_nxt) used_nxt = (locked_vec & valid_vec) | hit_onehot;
    end
    if (ins_en) used_nxt[ins_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= used_nxt;
  end

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) used_cnt = used_cnt + (IDX_W+1)'(used_q[i]);
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
    (|free_vec) |-> (!valid_vec[victim] || !used_q[victim])); // R8

  AST_FILL_CLEARS_USED: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> !used_q[$past(ins_idx)]); // R7

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PART_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_sel,
  input  logic [10:0]                  cfg_addr,
  input  logic [63:0]                  cfg_wdata,
  output logic [63:0]                  tag_access_o,
  input  logic                         lk_req,
  input  logic [63:0]                  lk_va,
  input  logic [12:0]                  lk_ctx,
  input  logic                         lk_rmode,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [$clog2(ENTRIES)-1:0]   rsp_idx,
  output logic [39:0]                  rsp_pa,
  output logic [$clog2(ENTRIES):0]     used_cnt
);

  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int SLOT_LSB = 3;
  localparam int A_RMODE  = 9;
  localparam int A_ALT    = 10;

  cfg_sel_e                     sel;
  tlb_entry_t [ENTRIES-1:0]     ent_q;
  logic [ENTRIES-1:0][PART_W-1:0] part_arr_q;
  logic [PART_W-1:0]            part_q;
  logic [63:0]                  tagacc_q;
  logic [63:0]                  pte_new;
  logic [ENTRIES-1:0]           valid_vec;
  logic [ENTRIES-1:0]           locked_vec;
  logic [ENTRIES-1:0]           hit_vec;
  logic [ENTRIES-1:0]           used_q;
  logic                         any_hit;
  logic [IDX_W-1:0]             hit_idx;
  logic [IDX_W-1:0]             victim;
  logic [IDX_W-1:0]             slot_idx;
  logic [IDX_W-1:0]             ins_idx;
  logic                         ins_en;
  logic [PA_W-1:0]              pa_calc;

  assign sel      = cfg_sel_e'(cfg_sel);
  assign slot_idx = cfg_addr[SLOT_LSB +: IDX_W];
  assign ins_en   = cfg_we && ((sel == CFG_FILL) || (sel == CFG_SLOT));
  assign ins_idx  = (sel == CFG_SLOT) ? slot_idx : victim;

  tlb_pte_fmt u_fmt (
    .alt    (cfg_addr[A_ALT]),
    .raw    (cfg_wdata),
    .native (pte_new)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    assign valid_vec[g]  = ent_q[g].pte[B_VALID];
    assign locked_vec[g] = ent_q[g].pte[B_VALID] & ent_q[g].pte[B_LOCK];
  end

  tlb_match #(.ENTRIES(ENTRIES), .PART_W(PART_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .ents     (ent_q),
    .parts    (part_arr_q),
    .part_cur (part_q),
    .lk_va    (lk_va),
    .lk_ctx   (lk_ctx),
    .lk_rmode (lk_rmode),
    .hit_vec  (hit_vec)
  );

  // lowest-numbered match wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit_vec;

  tlb_nru #(.ENTRIES(ENTRIES)) u_nru (
    .clk        (clk),
    .rst        (rst),
    .valid_vec  (valid_vec),
    .locked_vec (locked_vec),
    .hit_en     (lk_req && any_hit),
    .hit_idx    (hit_idx),
    .ins_en     (ins_en),
    .ins_idx    (ins_idx),
    .used_q     (used_q),
    .victim     (victim),
    .used_cnt   (used_cnt)
  );

  // physical address merge for the hitting entry
  always_comb begin
    logic [63:0]     hp;
    logic [5:0]      sh;
    logic [PA_W-1:0] off_m;
    logic [PA_W-1:0] page;
    hp      = ent_q[hit_idx].pte;
    sh      = page_shift(size_code(hp));
    off_m   = PA_W'((64'd1 << sh) - 64'd1);
    page    = {hp[B_PA_HI:PG_LSB], {PG_LSB{1'b0}}};
    pa_calc = (page & ~off_m) | (lk_va[PA_W-1:0] & off_m);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q      <= '0;
      part_arr_q <= '0;
    end else if (ins_en) begin
      ent_q[ins_idx] <= '{vtag:  tagacc_q[63:PG_LSB],
                          ctx:   tagacc_q[CTX_W-1:0],
                          rmode: cfg_addr[A_RMODE],
                          pte:   pte_new};
      part_arr_q[ins_idx] <= part_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tagacc_q <= '0;
      part_q   <= '0;
    end else begin
      if (cfg_we && sel == CFG_TAG)       tagacc_q <= cfg_wdata;
      else if (lk_req && !any_hit)        tagacc_q <= {lk_va[63:PG_LSB], lk_ctx};
      if (cfg_we && sel == CFG_PART)      part_q   <= cfg_wdata[PART_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && any_hit;
      rsp_idx   <= hit_idx;
      rsp_pa    <= pa_calc;
    end
  end

  assign tag_access_o = tagacc_q;

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid); // R2

  AST_MISS_LOADS_TAG: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !any_hit && !(cfg_we && sel == CFG_TAG))
    |=> (tag_access_o == {$past(lk_va[63:PG_LSB]), $past(lk_ctx)})); // R5

  AST_HIT_MARKS_USED: assert property (@(posedge clk) disable iff (rst)
    (lk_req && any_hit && !(ins_en && ins_idx == hit_idx))
    |=> used_q[$past(hit_idx)]); // R11

  AST_SLOT_TAG: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sel == CFG_SLOT)
    |=> (ent_q[$past(slot_idx)].vtag == $past(tagacc_q[63:PG_LSB]))); // R9

endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;

  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [10:0] cfg_addr;
  logic [63:0] cfg_wdata;
  logic [63:0] tag_access_o;
  logic        lk_req;
  logic [63:0] lk_va;
  logic [12:0] lk_ctx;
  logic        lk_rmode;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic [39:0] rsp_pa;
  logic [IW:0] used_cnt;

  tlb_fa #(.ENTRIES(N), .PART_W(8)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tag_access_o(tag_access_o), .lk_req(lk_req), .lk_va(lk_va),
    .lk_ctx(lk_ctx), .lk_rmode(lk_rmode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_pa(rsp_pa), .used_cnt(used_cnt)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model
  logic [63:0] m_pte [N];
  logic [50:0] m_tag [N];
  logic [12:0] m_ctx [N];
  logic [7:0]  m_prt [N];
  logic        m_rm  [N];
  logic [N-1:0] m_used;
  logic [63:0] m_ta;
  logic [7:0]  m_part;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] f_conv(input logic [63:0] d);
    logic [63:0] o = '0;
    o[63] = d[63]; o[62] = d[1]; o[61] = d[0]; o[48] = d[2];
    o[60] = d[62]; o[59] = d[12]; o[39:13] = d[39:13]; o[6] = d[61];
    o[5] = d[10]; o[4] = d[9]; o[3] = d[11]; o[2] = d[8]; o[1] = d[6];
    return o;
  endfunction

  function automatic int f_code(input logic [63:0] p);
    return int'({p[48], p[62], p[61]});
  endfunction

  function automatic int f_find(input logic [63:0] va, input logic [12:0] cx, input bit rm);
    for (int i = 0; i < N; i++) begin
      int sh = 13 + 3 * f_code(m_pte[i]);
      if (m_pte[i][63] && f_code(m_pte[i]) < 6 && m_prt[i] == m_part && m_rm[i] == rm
          && (rm || m_ctx[i] == cx) && ((va >> sh) == ({m_tag[i], 13'b0} >> sh)))
        return i;
    end
    return -1;
  endfunction

  function automatic logic [39:0] f_pa(input int h, input logic [63:0] va);
    int sh = 13 + 3 * f_code(m_pte[h]);
    logic [63:0] msk = (64'd1 << sh) - 64'd1;
    logic [63:0] pg = {24'b0, m_pte[h][39:13], 13'b0};
    return 40'((pg & ~msk) | (va & msk));
  endfunction

  function automatic int f_victim();
    for (int i = 0; i < N; i++) if (!m_pte[i][63] || !m_used[i]) return i;
    return N - 1;
  endfunction

  function automatic logic [N-1:0] f_locked();
    logic [N-1:0] l;
    for (int i = 0; i < N; i++) l[i] = m_pte[i][63] & m_pte[i][6];
    return l;
  endfunction

  function automatic logic [63:0] f_pool(input int i);
    return 64'hC0DE_0000_0000_0000 ^ (64'(i) << 29) ^ (64'(i & 1) << 45) ^ (64'(i >> 1) << 17);
  endfunction

  // one cycle: optional config write and optional lookup, checked against the model
  task automatic op(input bit dc, input logic [1:0] s, input logic [10:0] a, input logic [63:0] d,
                    input bit dl, input logic [63:0] va, input logic [12:0] cx, input bit rm,
                    input string tag);
    int h, v, idx;
    logic [39:0] epa;
    logic [63:0] old_ta;
    cfg_we = dc; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    lk_req = dl; lk_va = va; lk_ctx = cx; lk_rmode = rm;
    h   = f_find(va, cx, rm);
    epa = (h >= 0) ? f_pa(h, va) : 40'd0;
    v   = f_victim();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; lk_req = 1'b0;
    old_ta = m_ta;
    if (dl && h >= 0) begin
      m_used[h] = 1'b1;
      if (&m_used) m_used = f_locked() | (N'(1) << h);
    end
    if (dc) begin
      case (s)
        2'd0: m_ta = d;
        2'd1: m_part = d[7:0];
        default: begin
          idx = (s == 2'd3) ? int'(a[5:3]) : v;
          m_pte[idx] = a[10] ? f_conv(d) : d;
          m_tag[idx] = old_ta[63:13];
          m_ctx[idx] = old_ta[12:0];
          m_prt[idx] = m_part;
          m_rm[idx]  = a[9];
          m_used[idx] = 1'b0;
        end
      endcase
    end
    if (dl && h < 0 && !(dc && s == 2'd0)) m_ta = {va[63:13], cx};
    chk(rsp_valid == dl, {tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'(dl));
    if (dl) begin
      chk(rsp_hit == (h >= 0), {tag, " R2 hit"}, 64'(rsp_hit), 64'(h >= 0));
      if (h >= 0) begin
        chk(rsp_idx == IW'(h), {tag, " R2 idx"}, 64'(rsp_idx), 64'(h));
        chk(rsp_pa == epa, {tag, " R3 pa"}, 64'(rsp_pa), 64'(epa));
      end
    end
    chk(used_cnt == (IW+1)'($countones(m_used)), {tag, " R11 used_cnt"},
        64'(used_cnt), 64'($countones(m_used)));
    chk(tag_access_o == m_ta, {tag, " R5 tag-access"}, tag_access_o, m_ta);
  endtask

  task automatic cfg(input logic [1:0] s, input logic [10:0] a, input logic [63:0] d, input string tag);
    op(1'b1, s, a, d, 1'b0, 64'd0, 13'd0, 1'b0, tag);
  endtask

  task automatic look(input logic [63:0] va, input logic [12:0] cx, input bit rm, input string tag);
    op(1'b0, 2'd0, 11'd0, 64'd0, 1'b1, va, cx, rm, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, requirement R2 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] base, pte, va, d;
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_wdata = 0;
    lk_req = 0; lk_va = 0; lk_ctx = 0; lk_rmode = 0;
    for (int i = 0; i < N; i++) begin
      m_pte[i] = 0; m_tag[i] = 0; m_ctx[i] = 0; m_prt[i] = 0; m_rm[i] = 0;
    end
    m_used = 0; m_ta = 0; m_part = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tag_access_o == 0, "R1 tag-access after reset", tag_access_o, 0);
    chk(used_cnt == 0, "R1 used_cnt after reset", 64'(used_cnt), 0);
    look(64'h0, 13'd0, 1'b0, "R1 empty");

    // size sweep with indexed fills
    for (int sc = 0; sc < 8; sc++) begin
      for (int rm = 0; rm < 2; rm++) begin
        int sh = 13 + 3 * sc;
        base = 64'h5A00_0000_0000_0000 | (64'(sc * 2 + rm) << 40);
        cfg(2'd0, 11'd0, base | 64'd5, "R6");
        pte = 64'h8000_0000_0000_0000 | ({37'b0, 27'h2AB_CDEF ^ 27'(sc * 1234567)} << 13);
        pte[62:61] = 2'(sc); pte[48] = sc[2];
        cfg(2'd3, {1'b0, 1'(rm), 3'b0, 3'(sc), 3'b0}, pte, "R9");
        for (int k = 0; k < 4; k++) begin
          logic [63:0] off;
          off = (k == 0) ? 64'd0 : (k == 1) ? ~64'd0 : (k == 2) ? 64'hA5A5_A5A5 : 64'h5A5A_5A5A;
          va = base | (off & ((64'd1 << sh) - 64'd1));
          look(va, 13'd5, 1'(rm), (sc >= 6) ? "R4" : "R3");
        end
        look(base, 13'd6, 1'(rm), "R2 ctx");
        look(base, 13'd5, 1'(1 - rm), "R2 rmode");
        if (sc < 6) look(base + (64'd1 << sh), 13'd5, 1'(rm), "R2 next page");
      end
    end

    // partition
    cfg(2'd1, 11'd0, 64'd3, "R6 partition");
    look(64'h5A00_0B00_0000_0000, 13'd5, 1'b1, "R7 other partition");
    cfg(2'd1, 11'd0, 64'd0, "R6 partition");
    look(64'h5A00_0B00_0000_0000, 13'd5, 1'b1, "R7 partition back");

    // alternate layout
    for (int k = 0; k < 24; k++) begin
      va = f_pool(k % 8);
      cfg(2'd0, 11'd0, va | 64'(k % 2), "R6");
      d = {$urandom, $urandom};
      d[63] = 1'b1; d[2] = 1'b0;
      cfg(2'd3, {1'b1, 1'(k % 2), 3'b0, 3'(k), 3'b0}, d, "R10");
      look(va | 64'($urandom & 32'h0FFF_FFFF), 13'(k % 2), 1'(k % 2), "R10");
    end

    // policy fills
    for (int k = 0; k < 12; k++) begin
      cfg(2'd0, 11'd0, f_pool(k % 8) ^ (64'(k) << 50), "R6");
      d = 64'h8000_0000_0000_0000 | (64'(k) << 13) | ((k == 3) ? 64'h40 : 64'h0);
      cfg(2'd2, 11'd0, d, "R8");
      look(f_pool(k % 8) ^ (64'(k) << 50), 13'd0, 1'b0, "R8");
    end
    for (int k = 0; k < 12; k++) look(f_pool(k % 8) ^ (64'(k) << 50), 13'd0, 1'b0, "R11 sweep");
    for (int k = 0; k < 3; k++) cfg(2'd2, 11'd0, 64'h8000_0000_0000_0000 | 64'(k << 20), "R8 full");

    // same-cycle cases
    op(1'b1, 2'd0, 11'd0, 64'h1111_2222_3333_4444, 1'b1, 64'h7777_0000_0000_0000, 13'd9, 1'b0, "R12 miss+tagwrite");
    cfg(2'd0, 11'd0, f_pool(2), "R6");
    cfg(2'd3, {5'b0, 3'd4, 3'b0}, 64'h8000_0000_00AB_C000, "R9");
    op(1'b1, 2'd3, {5'b0, 3'd4, 3'b0}, 64'h8000_0000_0012_3000, 1'b1, f_pool(2), 13'd0, 1'b0, "R12 hit+refill");
    look(f_pool(2), 13'd0, 1'b0, "R12 after refill");
    op(1'b1, 2'd2, 11'd0, 64'h8000_0000_0045_6000, 1'b1, f_pool(2), 13'd0, 1'b0, "R12 hit+policy");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      bit dc = (r < 5);
      bit dl = (r >= 3);
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [10:0] a;
      if (s == 2'd1 && $urandom_range(0, 3) != 0) s = 2'd0;
      a = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'b0, 3'($urandom_range(0, 7)), 3'b0};
      case (s)
        2'd0: d = f_pool($urandom_range(0, 7)) | 64'($urandom_range(0, 1));
        2'd1: d = 64'($urandom_range(0, 1));
        default: begin
          d = {$urandom, $urandom};
          d[63] = ($urandom_range(0, 7) != 0);
          if (a[10]) d[2] = ($urandom_range(0, 5) == 0);
          else       d[48] = ($urandom_range(0, 5) == 0);
        end
      endcase
      va = f_pool($urandom_range(0, 7)) | 64'($urandom & 32'h0FFF_FFFF);
      op(dc, s, a, d, dl, va, 13'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R12 mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule